// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block watches a NOR flash while the flash runs an internal program or erase algorithm, and reports when that work has ended. After a start pulse it reads one status location again and again through a simple request/ready read port. Each poll step is a pair of back-to-back reads. While the algorithm runs, the flash flips a toggle bit on every read. When two reads in a row return the same toggle bit, the work is finished.

When the toggle bit differs, the poller looks at a fault bit in the first read of the pair. If the fault bit is set, the poller takes one more pair of reads to confirm. A second pair that still toggles with the fault bit set gives an error. A cycle-count timeout, loaded with each start, bounds the whole wait. A value of zero means the result is timeout at once. The all-ones value turns the timeout off.

The outcome appears on a two-bit result code. The code is held until the next accepted start. The bus timing of the flash and its algorithm itself are outside this block.

Top module: `toggle_poll`

## Requirements
- R1: After reset `busy_o` is 0, `result_o` is 2'b00 and `rd_req_o` is 0.
- R2: A `start_i` pulse seen while idle with a nonzero timeout raises `busy_o` at that edge. It clears `result_o` to 2'b00 and captures `addr_i`. `rd_addr_o` then shows the captured address, unchanged, until `busy_o` falls.
- R3: `rd_req_o` is high while busy. A read completes at each rising edge where `rd_req_o` and `rd_ready_i` are both high, and `rd_data_i` is sampled at that edge. Idle cycles of `rd_ready_i` only stretch the wait.
- R4: If bit 6 of `rd_data_i` is equal in the two reads of a pair, the poll ends with result 2'b01 (success), and `busy_o` falls at the edge that completes the second read.
- R5: If bit 6 differs within a pair and bit 5 of the first read of that pair is 0, the poller starts a new pair.
- R6: If bit 6 differs and bit 5 of the first read is 1, a confirmation pair follows. In that pair, equal bit 6 gives success (2'b01). Differing bit 6 with bit 5 of its first read set gives 2'b10 (error). Differing bit 6 with bit 5 clear goes back to ordinary polling.
- R7: A start with `tmo_i` = 0 sets `result_o` to 2'b11 (timeout) at the next edge. `busy_o` does not rise and no read is requested.
- R8: With 0 < `tmo_i` < all-ones and no decision, `busy_o` stays high for exactly `tmo_i`+1 cycles and then falls with result 2'b11.
- R9: With `tmo_i` all-ones the poller never reports timeout; it waits for as long as the reads take.
- R10: If a read decides success or error in the same cycle that the timeout expires, the read decision is reported, not timeout.
- R11: `result_o` holds its value until the next accepted start. A `start_i` pulse while busy is ignored: the address, the timeout and the running sequence stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start request |
| addr_i | input | AW | Status location to poll, captured on start |
| tmo_i | input | TW | Timeout in cycles, captured on start (0 = immediate, all-ones = none) |
| rd_req_o | output | 1 | Read request toward the flash bus |
| rd_addr_o | output | AW | Read address |
| rd_ready_i | input | 1 | Read completes at this edge when high with the request |
| rd_data_i | input | DW | Read data, valid with `rd_ready_i` |
| busy_o | output | 1 | High while polling |
| result_o | output | 2 | 00 none, 01 success, 10 error, 11 timeout |

## Verification
The expiry of the timeout counter and a read completion that decides the outcome can fall on the same edge. The bench forces this with a timeout of one and a flash model that answers every cycle. The pair's second read then lands in the very cycle the count expires. With two equal status words it expects success after two busy cycles. With toggling words it expects timeout after the same two cycles. Those two cases show the read decision taking priority, while the counter still ends polls that never resolve.

// File: rtl/toggle_poll.sv
module toggle_poll #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int TW      = 16,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] tmo_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ready_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic [1:0]    result_o
);

  localparam logic [1:0]    RES_OK  = 2'b01;
  localparam logic [1:0]    RES_ERR = 2'b10;
  localparam logic [1:0]    RES_TMO = 2'b11;
  localparam logic [TW-1:0] NO_TMO  = '1;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} st_t;

  st_t           st;
  logic [AW-1:0] addr_r;
  logic [TW-1:0] tmo_r, cnt;
  logic          conf, f_tog, f_err;

  logic hs, match, fail, decide, expire;

  assign busy_o    = (st != S_IDLE);
  assign rd_req_o  = busy_o;
  assign rd_addr_o = addr_r;

  assign hs     = rd_req_o && rd_ready_i;
  assign match  = (rd_data_i[TOG_BIT] == f_tog);
  assign fail   = !match && conf && f_err;
  assign decide = hs && (st == S_SECOND) && (match || fail);
  assign expire = (tmo_r != NO_TMO) && (cnt == tmo_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_r   <= '0;
      tmo_r    <= '0;
      cnt      <= '0;
      conf     <= 1'b0;
      f_tog    <= 1'b0;
      f_err    <= 1'b0;
      result_o <= 2'b00;
    end else if (st == S_IDLE) begin
      if (start_i) begin
        addr_r <= addr_i;
        tmo_r  <= tmo_i;
        cnt    <= '0;
        conf   <= 1'b0;
        if (tmo_i == '0) result_o <= RES_TMO;
        else begin
          result_o <= 2'b00;
          st       <= S_FIRST;
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (hs && st == S_FIRST) begin
        f_tog <= rd_data_i[TOG_BIT];
        f_err <= rd_data_i[ERR_BIT];
        st    <= S_SECOND;
      end
      if (hs && st == S_SECOND) begin
        if (match) begin
          st       <= S_IDLE;
          result_o <= RES_OK;
        end else if (fail) begin
          st       <= S_IDLE;
          result_o <= RES_ERR;
        end else begin
          conf <= !conf && f_err;
          st   <= S_FIRST;
        end
      end
      if (expire && !decide) begin
        st       <= S_IDLE;
        result_o <= RES_TMO;
      end
    end
  end

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(result_o));

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (result_o == 2'b00));

  // R4
  code_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (result_o != 2'b00));

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

  // R9
  no_tmo_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && result_o == RES_TMO) |-> (tmo_r != NO_TMO));

endmodule

// File: tb/toggle_poll_test.sv
`timescale 1ns/1ps
module toggle_poll_test;
  localparam int AW = 24, DW = 16, TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [TW-1:0] tmo_i = '0;
  logic          rd_req_o, rd_ready_i = 1'b0, busy_o;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i;
  logic [1:0]    result_o;

  toggle_poll #(.AW(AW), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .tmo_i(tmo_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ready_i(rd_ready_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .result_o(result_o));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] words [64];
  int nreads = 0, rbase = 0, cyc = 0;
  bit slow = 1'b0;
  int q_res[$], q_rd[$], q_bc[$];

  assign rd_data_i = words[(nreads - rbase) & 63];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_req_o && rd_ready_i) nreads <= nreads + 1;
  end

  always @(negedge clk) rd_ready_i = rd_req_o && (!slow || (cyc % 3) == 0);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  bit prev_busy = 1'b0;
  int base = 0, bcnt = 0;
  always @(negedge clk) begin
    if (busy_o && !prev_busy) begin base = nreads; bcnt = 0; end
    if (busy_o) bcnt++;
    if (!busy_o && prev_busy) begin
      if (q_res.size() == 0) chk("R11 unexpected completion", 1, 0);
      else begin
        int er, erd, ebc;
        er = q_res.pop_front(); erd = q_rd.pop_front(); ebc = q_bc.pop_front();
        chk("R4/R6/R8 result code", int'(result_o), er);
        if (erd >= 0) chk("R3/R5/R6 read count", nreads - base, erd);
        if (ebc >= 0) chk("R8/R10 busy cycles", bcnt, ebc);
      end
    end
    prev_busy = busy_o;
  end

  function automatic logic [DW-1:0] sw(input bit b6, input bit b5);
    return {9'b0, b6, b5, 5'b0};
  endfunction

  task automatic fill_toggle();
    for (int i = 0; i < 64; i++) words[i] = sw(i[0] == 1'b0, 1'b0);
  endtask

  task automatic launch(input logic [AW-1:0] a, input logic [TW-1:0] t,
                        input int er, input int erd, input int ebc);
    q_res.push_back(er); q_rd.push_back(erd); q_bc.push_back(ebc);
    @(negedge clk);
    rbase = nreads;
    start_i = 1'b1; addr_i = a; tmo_i = t;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", int'(busy_o), 1);
    chk("R2 result cleared", int'(result_o), 0);
    chk("R2 read address", int'(rd_addr_o), int'(a));
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fill_toggle();
    repeat (3) @(negedge clk);
    chk("R1 busy reset", int'(busy_o), 0);
    chk("R1 result reset", int'(result_o), 0);
    chk("R1 req reset", int'(rd_req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 equal first pair
    words[0] = sw(1,0); words[1] = sw(1,0);
    launch(24'h000100, 16'hFFFF, 1, 2, -1); wait_idle();

    // R5 toggle with fault clear, then equal
    words[0] = sw(1,0); words[1] = sw(0,0); words[2] = sw(0,0); words[3] = sw(0,0);
    launch(24'h000200, 16'hFFFF, 1, 4, -1); wait_idle();

    // R6 fault set, confirmation equal
    words[0] = sw(1,1); words[1] = sw(0,0); words[2] = sw(1,0); words[3] = sw(1,0);
    launch(24'h000300, 16'hFFFF, 1, 4, -1); wait_idle();

    // R6 error
    words[0] = sw(1,1); words[1] = sw(0,0); words[2] = sw(1,1); words[3] = sw(0,0);
    launch(24'h000400, 16'hFFFF, 2, 4, -1); wait_idle();

    // R6 confirmation toggles with fault clear -> keep polling
    words[0] = sw(1,1); words[1] = sw(0,0); words[2] = sw(1,0); words[3] = sw(0,0);
    words[4] = sw(1,0); words[5] = sw(1,0);
    launch(24'h000500, 16'hFFFF, 1, 6, -1); wait_idle();

    // R7 zero timeout
    @(negedge clk);
    start_i = 1'b1; addr_i = 24'h000600; tmo_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 result timeout", int'(result_o), 3);
    chk("R7 busy stays low", int'(busy_o), 0);
    chk("R7 no read request", int'(rd_req_o), 0);
    @(negedge clk);

    // R8 timeout of 5 with endless toggling
    fill_toggle();
    launch(24'h000700, 16'd5, 3, -1, 6); wait_idle();

    // R9 timeout off, slow bus, 42 reads
    fill_toggle(); words[40] = sw(0,0); words[41] = sw(0,0);
    slow = 1'b1;
    launch(24'h000800, 16'hFFFF, 1, 42, -1); wait_idle();
    slow = 1'b0;

    // R10 decision and expiry in the same cycle
    words[0] = sw(1,0); words[1] = sw(1,0);
    launch(24'h000900, 16'd1, 1, 2, 2); wait_idle();
    fill_toggle();
    launch(24'h000A00, 16'd1, 3, 2, 2); wait_idle();

    // R11 start while busy ignored, result held
    words[0] = sw(1,0); words[1] = sw(0,0); words[2] = sw(0,0); words[3] = sw(0,0);
    slow = 1'b1;
    launch(24'h000B00, 16'hFFFF, 1, 4, -1);
    start_i = 1'b1; addr_i = 24'h777777; tmo_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R11 address kept", int'(rd_addr_o), 32'h000B00);
    chk("R11 still busy", int'(busy_o), 1);
    wait_idle();
    slow = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 result held", int'(result_o), 1);
    chk("R11 queue drained", q_res.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule